// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital bus side of a single-channel voice codec. It watches a bit clock and two frame-sync inputs, one for each direction, and finds an 8-bit transmit slot and an 8-bit receive slot within each frame. In the transmit slot it shifts out a byte taken from a parallel port, MSB first. In the receive slot it captures a byte from the serial receive line and presents it on a parallel port with a one-cycle strobe. Parallel byte ports take the place of the converter.

Two sync timings are supported. In long-frame timing the slot begins on the bit-clock rising edge where the sync is first seen high. Slot selection is unused in this timing. In short-frame timing the sync is sampled high on a falling edge, and the frame begins on the next rising edge. A 6-bit slot number per direction then picks which 8-bit slot of the frame is used. Transmit and receive framing run on separate counters, so the two frames may be skewed by any number of bit clocks. An active-low enable for an external bus driver covers the transmit slot. It releases half a bit early.

The block runs on one system clock. The bit clock, syncs and serial data are sampled inputs, and their edges are detected inside the block.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, dx_oe is 0, ts_en_n is 1, rx_valid is 0 and rx_byte is 0x00.
- R2: With short_frame = 0, the transmit (receive) slot starts at the first bit-clock rising edge at which fs_tx (fs_rx) is high after being low at the previous rising edge. tx_slot and rx_slot are ignored in this timing.
- R3: In its transmit slot the block drives the 8 bits of tx_byte on tx_data_out, MSB first, changing only on bit-clock rising edges. dx_oe is 1 for exactly those 8 bit periods and 0 otherwise.
- R4: With short_frame = 1, a sync that is high on a falling bit-clock edge, after being low on the previous one, marks the frame. The bit period that starts on the next rising edge is bit 0 of slot 0, and slot n starts 8n bit periods later.
- R5: A selected slot that the frame does not reach before the next sync restarts it produces no transmit drive and no received byte.
- R6: ts_en_n goes low at the first rising edge of the transmit slot. It returns high at the falling edge inside the eighth bit period, so it is low for 7.5 bit times.
- R7: In the receive slot, rx_data_in is sampled on the 8 falling bit-clock edges, first bit as MSB of the byte.
- R8: On the falling edge one bit clock after the last receive bit is sampled, rx_byte takes the captured byte and rx_valid is 1 for one system-clock cycle. rx_byte then holds until the next received byte.
- R9: Transmit and receive framing are independent. Each direction uses only its own sync and slot number, and any skew between them is allowed.
- R10: While power_down is 1, dx_oe is 0 and ts_en_n is 1 from the next system-clock cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| bclk | input | 1 | PCM bit clock, sampled |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| short_frame | input | 1 | 1 = short-frame timing with slot selection, 0 = long-frame timing |
| tx_slot | input | 6 | Transmit slot number (short-frame timing only) |
| rx_slot | input | 6 | Receive slot number (short-frame timing only) |
| power_down | input | 1 | Forces the transmit driver and its enable inactive |
| tx_byte | input | 8 | Byte to send in the transmit slot |
| rx_data_in | input | 1 | Serial receive data |
| tx_data_out | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit output enable; 0 means the line is high impedance |
| ts_en_n | output | 1 | Active-low enable for an external bus driver |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |

## Verification
The assertions assume that each bit-clock phase lasts at least two system-clock cycles. Under that assumption, rising and falling edges are never in adjacent cycles, the output strobe cannot repeat, and outputs stay unchanged between edges. The bench holds each bit-clock phase for four system cycles. It changes the syncs and the receive data only together with a rising bit-clock edge, so every sync is seen cleanly at one edge. Each stimulus row starts from reset, so no frame from an earlier row can reach into the next.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    typedef enum logic {
        FS_LONG  = 1'b0,
        FS_SHORT = 1'b1
    } fs_mode_e;

    localparam int BITS_PER_SLOT = 8;
    localparam int IDX_W         = $clog2(BITS_PER_SLOT);
    localparam int N_DIR         = 2;
    localparam int DIR_TX        = 0;
    localparam int DIR_RX        = 1;

endpackage

// File: rtl/pcm_slot_framer.sv
module pcm_slot_framer
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_rise,
    input  logic                 bclk_fall,
    input  logic                 fs,
    input  fs_mode_e             mode,
    input  logic [SLOT_W-1:0]    slot_sel,
    output logic                 in_slot,
    output logic [IDX_W-1:0]     bit_idx
);

    localparam int POS_W = SLOT_W + IDX_W;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic             fs_prev;
        logic             armed;
        logic             run;
        logic [POS_W-1:0] pos;
    } fr_state_t;

    fr_state_t state_d, state_q;
    logic start, step;
    logic [SLOT_W-1:0] eff_slot;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        step    = 1'b0;
        if (mode == FS_SHORT) begin
            if (bclk_fall) begin
                state_d.fs_prev = fs;
                if (fs && !state_q.fs_prev) begin
                    state_d.armed = 1'b1;
                end
            end
            if (bclk_rise) begin
                if (state_q.armed) begin
                    start         = 1'b1;
                    state_d.armed = 1'b0;
                end else begin
                    step = state_q.run;
                end
            end
        end else begin
            state_d.armed = 1'b0;
            if (bclk_rise) begin
                state_d.fs_prev = fs;
                start = fs && !state_q.fs_prev;
                step  = state_q.run && !start;
            end
        end
        if (start) begin
            state_d.run = 1'b1;
            state_d.pos = '0;
        end else if (step) begin
            if (state_q.pos == POS_MAX) begin
                state_d.run = 1'b0;
            end else begin
                state_d.pos = state_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign eff_slot = (mode == FS_SHORT) ? slot_sel : '0;
    assign in_slot  = state_q.run && (state_q.pos[POS_W-1:IDX_W] == eff_slot);
    assign bit_idx  = state_q.pos[IDX_W-1:0];

    // R4
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(state_q.pos));

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
    import pcm_slot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk_rise,
    input  logic                     bclk_fall,
    input  logic                     in_slot,
    input  logic [IDX_W-1:0]         bit_idx,
    input  logic [BITS_PER_SLOT-1:0] tx_byte,
    input  logic                     power_down,
    output logic                     tx_data_out,
    output logic                     dx_oe,
    output logic                     ts_en_n
);

    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BITS_PER_SLOT - 1);

    typedef struct packed {
        logic [BITS_PER_SLOT-1:0] sh;
        logic                     dout;
        logic                     oe;
        logic                     tsn;
    } tx_state_t;

    tx_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (bclk_rise) begin
            if (in_slot) begin
                state_d.oe  = 1'b1;
                state_d.tsn = 1'b0;
                if (bit_idx == '0) begin
                    state_d.dout = tx_byte[BITS_PER_SLOT-1];
                    state_d.sh   = {tx_byte[BITS_PER_SLOT-2:0], 1'b0};
                end else begin
                    state_d.dout = state_q.sh[BITS_PER_SLOT-1];
                    state_d.sh   = {state_q.sh[BITS_PER_SLOT-2:0], 1'b0};
                end
            end else begin
                state_d.oe   = 1'b0;
                state_d.tsn  = 1'b1;
                state_d.dout = 1'b0;
            end
        end
        if (bclk_fall && in_slot && (bit_idx == LAST_BIT)) begin
            state_d.tsn = 1'b1;
        end
        if (power_down) begin
            state_d.oe  = 1'b0;
            state_d.tsn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.tsn <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_data_out = state_q.dout;
    assign dx_oe       = state_q.oe;
    assign ts_en_n     = state_q.tsn;

    // R10
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!dx_oe && ts_en_n));

    // R6
    tsn_inside_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_en_n |-> dx_oe);

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(tx_data_out));

endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx
    import pcm_slot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk_fall,
    input  logic                     in_slot,
    input  logic [IDX_W-1:0]         bit_idx,
    input  logic                     rx_data_in,
    output logic [BITS_PER_SLOT-1:0] rx_byte,
    output logic                     rx_valid
);

    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BITS_PER_SLOT - 1);

    typedef struct packed {
        logic [BITS_PER_SLOT-1:0] sh;
        logic                     done;
        logic [BITS_PER_SLOT-1:0] held;
        logic                     valid;
    } rx_state_t;

    rx_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (bclk_fall) begin
            if (state_q.done) begin
                state_d.held  = state_q.sh;
                state_d.valid = 1'b1;
                state_d.done  = 1'b0;
            end
            if (in_slot) begin
                state_d.sh = {state_q.sh[BITS_PER_SLOT-2:0], rx_data_in};
                if (bit_idx == LAST_BIT) begin
                    state_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rx_byte  = state_q.held;
    assign rx_valid = state_q.valid;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk,
    input  logic                     fs_tx,
    input  logic                     fs_rx,
    input  logic                     short_frame,
    input  logic [SLOT_W-1:0]        tx_slot,
    input  logic [SLOT_W-1:0]        rx_slot,
    input  logic                     power_down,
    input  logic [BITS_PER_SLOT-1:0] tx_byte,
    input  logic                     rx_data_in,
    output logic                     tx_data_out,
    output logic                     dx_oe,
    output logic                     ts_en_n,
    output logic [BITS_PER_SLOT-1:0] rx_byte,
    output logic                     rx_valid
);

    typedef struct packed {
        logic bclk;
        logic rise_dly;
    } edge_state_t;

    edge_state_t edge_d, edge_q;
    logic        bclk_rise, bclk_fall;
    fs_mode_e    mode;

    logic [N_DIR-1:0]  fs_vec;
    logic [SLOT_W-1:0] slot_vec [N_DIR];
    logic [N_DIR-1:0]  in_slot_vec;
    logic [IDX_W-1:0]  bit_vec  [N_DIR];

    assign bclk_rise = bclk && !edge_q.bclk;
    assign bclk_fall = !bclk && edge_q.bclk;
    assign mode      = fs_mode_e'(short_frame);

    always_comb begin
        edge_d          = edge_q;
        edge_d.bclk     = bclk;
        edge_d.rise_dly = bclk_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign fs_vec[DIR_TX]   = fs_tx;
    assign fs_vec[DIR_RX]   = fs_rx;
    assign slot_vec[DIR_TX] = tx_slot;
    assign slot_vec[DIR_RX] = rx_slot;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        pcm_slot_framer #(.SLOT_W(SLOT_W)) u_framer (
            .clk       (clk),
            .rst_n     (rst_n),
            .bclk_rise (bclk_rise),
            .bclk_fall (bclk_fall),
            .fs        (fs_vec[g]),
            .mode      (mode),
            .slot_sel  (slot_vec[g]),
            .in_slot   (in_slot_vec[g]),
            .bit_idx   (bit_vec[g])
        );
    end

    pcm_slot_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (edge_q.rise_dly),
        .bclk_fall   (bclk_fall),
        .in_slot     (in_slot_vec[DIR_TX]),
        .bit_idx     (bit_vec[DIR_TX]),
        .tx_byte     (tx_byte),
        .power_down  (power_down),
        .tx_data_out (tx_data_out),
        .dx_oe       (dx_oe),
        .ts_en_n     (ts_en_n)
    );

    pcm_slot_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_fall  (bclk_fall),
        .in_slot    (in_slot_vec[DIR_RX]),
        .bit_idx    (bit_vec[DIR_RX]),
        .rx_data_in (rx_data_in),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid)
    );

endmodule

// File: tb/pcm_slot_port_bench.sv
module pcm_slot_port_bench;

    localparam int RUN   = 96;
    localparam int NROWS = 6;

    typedef struct packed {
        logic       dly;
        logic [5:0] txs;
        logic [5:0] rxs;
        logic [7:0] ftx;
        logic [7:0] frx;
        logic [7:0] per;
        logic [7:0] tb;
        logic [7:0] rb;
    } vec_t;

    localparam vec_t VEC [NROWS] = '{
        '{1'b0, 6'd3, 6'd5, 8'd2, 8'd5,  8'd64, 8'hA5, 8'h3C},
        '{1'b1, 6'd0, 6'd0, 8'd1, 8'd1,  8'd64, 8'h81, 8'h7E},
        '{1'b1, 6'd2, 6'd1, 8'd3, 8'd10, 8'd64, 8'hC3, 8'h96},
        '{1'b1, 6'd5, 6'd6, 8'd0, 8'd0,  8'd32, 8'h5A, 8'h55},
        '{1'b1, 6'd3, 6'd3, 8'd0, 8'd17, 8'd40, 8'h6D, 8'hE1},
        '{1'b0, 6'd0, 6'd0, 8'd4, 8'd9,  8'd16, 8'h37, 8'hB4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       fs_tx = 1'b0;
    logic       fs_rx = 1'b0;
    logic       short_frame = 1'b0;
    logic [5:0] tx_slot = '0;
    logic [5:0] rx_slot = '0;
    logic       power_down = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       rx_data_in = 1'b0;
    logic       tx_data_out, dx_oe, ts_en_n, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic oe_hi, d_hi, tsn_hi, tsn_lo;
    logic       vseen [RUN];
    logic [7:0] vbyte [RUN];

    always #10 clk = ~clk;

    pcm_slot_port u_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .short_frame(short_frame), .tx_slot(tx_slot), .rx_slot(rx_slot),
        .power_down(power_down), .tx_byte(tx_byte), .rx_data_in(rx_data_in),
        .tx_data_out(tx_data_out), .dx_oe(dx_oe), .ts_en_n(ts_en_n),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(posedge clk) begin
        if (rx_valid && cyc >= 0 && cyc < RUN) begin
            vseen[cyc] = 1'b1;
            vbyte[cyc] = rx_byte;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bclk = 1'b0; fs_tx = 1'b0; fs_rx = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one bit-clock period: 4 system cycles high, 4 low
    task automatic bit_cycle(input logic ft, input logic fr, input logic d);
        @(negedge clk);
        bclk = 1'b1; fs_tx = ft; fs_rx = fr; rx_data_in = d;
        repeat (2) @(negedge clk);
        oe_hi = dx_oe; d_hi = tx_data_out; tsn_hi = ts_en_n;
        repeat (2) @(negedge clk);
        bclk = 1'b0;
        repeat (2) @(negedge clk);
        tsn_lo = ts_en_n;
        @(negedge clk);
    endtask

    // bit index inside the selected slot at bit period c, or -1
    function automatic int slot_bit(int c, int f0, int per, bit dly, int slot);
        int d = dly ? 1 : 0;
        int o, p;
        if (c < f0 + d) return -1;
        o = f0 + ((c - d - f0) / per) * per;
        p = c - o - d;
        if (p >= 512) return -1;
        if ((p / 8) != (dly ? slot : 0)) return -1;
        return p % 8;
    endfunction

    task automatic run_row(input vec_t v, input int r);
        int tx_err = 0, tsn_err = 0, rx_err = 0;
        int nexp = 0;
        short_frame = v.dly; tx_slot = v.txs; rx_slot = v.rxs;
        tx_byte = v.tb; power_down = 1'b0;
        for (int i = 0; i < RUN; i++) begin
            vseen[i] = 1'b0;
            vbyte[i] = '0;
        end
        cyc = -1;
        do_reset();
        for (int c = 0; c < RUN; c++) begin
            logic ft, fr, d;
            int tb, rbit;
            ft = (c >= v.ftx) && (((c - v.ftx) % v.per) == 0);
            fr = (c >= v.frx) && (((c - v.frx) % v.per) == 0);
            rbit = slot_bit(c, v.frx, v.per, v.dly, v.rxs);
            d = (rbit >= 0) ? v.rb[7 - rbit] : c[0];
            cyc = c;
            bit_cycle(ft, fr, d);
            tb = slot_bit(c, v.ftx, v.per, v.dly, v.txs);
            if (tb >= 0) begin
                if (!oe_hi || d_hi !== v.tb[7 - tb]) tx_err++;
                if (tsn_hi !== 1'b0) tsn_err++;
                if (tsn_lo !== (tb == 7)) tsn_err++;
            end else begin
                if (oe_hi !== 1'b0) tx_err++;
                if (tsn_hi !== 1'b1 || tsn_lo !== 1'b1) tsn_err++;
            end
        end
        for (int c = 1; c < RUN; c++) begin
            bit e = (slot_bit(c - 1, v.frx, v.per, v.dly, v.rxs) == 7);
            if (e) nexp++;
            if (vseen[c] !== e) rx_err++;
            if (e && vbyte[c] !== v.rb) rx_err++;
        end
        // R2 R3 R4 R5 R9: transmit slot position and data
        check(tx_err == 0, $sformatf("R2 R3 R4 R5 R9 row %0d tx drive mismatches", r), tx_err, 0);
        // R6: driver enable window
        check(tsn_err == 0, $sformatf("R6 row %0d ts_en_n mismatches", r), tsn_err, 0);
        // R7 R8 R5 R9: receive capture and strobe timing
        check(rx_err == 0, $sformatf("R7 R8 R5 R9 row %0d rx mismatches", r), rx_err, 0);
        if (nexp > 0) begin
            // R8: byte held after the strobe
            check(rx_byte === v.rb, $sformatf("R8 row %0d rx_byte held", r), rx_byte, v.rb);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        cyc = -1;
        do_reset();
        // R1: reset state
        check(dx_oe === 1'b0, "R1 dx_oe after reset", dx_oe, 0);
        check(ts_en_n === 1'b1, "R1 ts_en_n after reset", ts_en_n, 1);
        check(rx_valid === 1'b0, "R1 rx_valid after reset", rx_valid, 0);
        check(rx_byte === 8'h00, "R1 rx_byte after reset", rx_byte, 0);

        for (int r = 0; r < NROWS; r++) run_row(VEC[r], r);

        // R10: power-down suppresses the driver in a slot that would be active
        short_frame = 1'b1; tx_slot = '0; rx_slot = '0; tx_byte = 8'hFF;
        cyc = -1;
        do_reset();
        power_down = 1'b1;
        bad = 0;
        for (int c = 0; c < 20; c++) begin
            cyc = c;
            bit_cycle(c == 0, 1'b0, 1'b0);
            if (oe_hi !== 1'b0 || tsn_hi !== 1'b1 || tsn_lo !== 1'b1) bad++;
        end
        check(bad == 0, "R10 power_down keeps driver off", bad, 0);

        // R10: drive resumes in the next frame after power_down is released
        power_down = 1'b0;
        bad = 0;
        for (int c = 0; c < 12; c++) begin
            cyc = c;
            bit_cycle(c == 0, 1'b0, 1'b0);
            if (c >= 1 && c <= 8 && (oe_hi !== 1'b1 || d_hi !== 1'b1)) bad++;
        end
        check(bad == 0, "R10 drive after release", bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule